// File: doc/BRIEF.md
# USB Device Interrupt Status and Vector Unit

This block gathers the event pulses that a full-speed USB device engine produces and keeps them in an 8-bit status register. Each pulse lasts one cycle, and its status bit stays set until software clears it. Any pending bit holds a single interrupt request line high. While that line is high, the block clears a control-transfer flag. It also loads a 4-bit code that names the most urgent pending source into a separate vector register, so that the interrupt controller can jump straight to the matching handler.

The CPU reaches two byte-wide locations through a simple register port. The status location is cleared by writing zeros and kept by writing ones. A clear mask with ones everywhere except the bits being serviced therefore cannot wipe out an event that lands between the read and the write. The vector location returns the vector code and the control flag, and the flag can be written from there. Five separate error-cause pulses feed one shared error bit. The DMA over/underrun event has a bit of its own and the highest urgency.

Top module: `usb_irq_status`

## Requirements
- R1: After reset the status location reads 00h, the vector location reads 00h, `irq_o` is 0, `vec_o` is 0 and `ctl_flag_o` is 0.
- R2: Bit 7 of the status location always reads 0, and writing it has no effect.
- R3: A one-cycle pulse on `dma_ovr_i` sets status bit 6 at the next clock edge. A pulse on `note_ev_i[k]` sets status bit k. From bit 4 down to bit 0, `note_ev_i` carries early-suspend, suspend, bus reset, start-of-frame and missed start-of-frame.
- R4: A pulse on any bit of `err_cause_i` sets status bit 5. Those bits are timeout, CRC, bit-stuffing, framing and buffer overrun, in any combination.
- R5: A write to the status location (`cpu_addr`=0) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is 1 exactly when at least one status bit is set, however many bits are set.
- R8: At each clock edge where the status register is nonzero, the vector register loads the index of the highest set status bit plus one (bit 6 gives 7, bit 0 gives 1). While the status register is zero, the vector register keeps its value.
- R9: At each clock edge where the status register is nonzero, the control flag is cleared. Otherwise a write to the vector location (`cpu_addr`=1) loads the flag from data bit 0. The vector location reads {3'b000, vector[3:0], flag}.
- R10: A CPU write that sets the control flag at an edge where the status register is nonzero is overridden, and the flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_ovr_i | input | 1 | DMA over/underrun event pulse |
| err_cause_i | input | 5 | Error cause pulses (timeout, CRC, stuffing, framing, buffer overrun) |
| note_ev_i | input | 5 | Notification pulses, bit 4 early-suspend down to bit 0 missed start-of-frame |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | Location select: 0 status, 1 vector/flag |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the selected location |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 4 | Current vector register contents |
| ctl_flag_o | output | 1 | Control-transfer flag |

## Verification
The assertions treat every event and cause input as a pulse that is sampled once per clock, and they assume that `cpu_addr` is stable whenever `cpu_wr` is high. The write-data checks also assume that no event lands on a bit in the same cycle that the property examines. The stimulus meets these assumptions by driving all inputs away from the clock edge, each for exactly one cycle, and returning them to idle before sampling. Random cycles mix sparse events with writes to either location and arbitrary masks. Directed cycles then force the collisions between a set and a clear, and between a hardware flag clear and a CPU flag set, on purpose.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

  localparam int STAT_W   = 8;
  localparam int CAUSE_W  = 5;
  localparam int NOTE_W   = 5;
  localparam int VEC_W    = 4;
  localparam int DMA_BIT  = 6;
  localparam int ERR_BIT  = 5;
  localparam int RSV_BIT  = 7;

  localparam logic [STAT_W-1:0] RSV_MASK = STAT_W'(1) << RSV_BIT;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_VECTOR = 1'b1
  } reg_sel_e;

  // Code for the highest set bit: index plus one, zero when empty.
  function automatic logic [VEC_W-1:0] top_pending_code(input logic [STAT_W-1:0] s);
    logic [VEC_W-1:0] code;
    logic found;
    code  = '0;
    found = 1'b0;
    for (int i = STAT_W - 1; i >= 0; i--) begin
      if (!found && s[i]) begin
        code  = VEC_W'(i + 1);
        found = 1'b1;
      end
    end
    return code;
  endfunction

  // New status value: set pulses win over clearing writes.
  function automatic logic [STAT_W-1:0] next_status(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] set,
    input logic              wr,
    input logic [STAT_W-1:0] keep
  );
    logic [STAT_W-1:0] kept;
    kept = wr ? (cur & keep) : cur;
    return (set | kept) & ~RSV_MASK;
  endfunction

endpackage

// File: rtl/usbirq_err_merge.sv
module usbirq_err_merge #(
  parameter int N = 5
) (
  input  logic [N-1:0] cause_i,
  output logic         err_o
);
  logic [N:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_or
    assign chain[g+1] = chain[g] | cause_i[g];
  end
  assign err_o = chain[N];
endmodule

// File: rtl/usbirq_status_reg.sv
module usbirq_status_reg
  import usbirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] keep_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] status_d;

  assign status_d = next_status(status_q, set_i, wr_i, keep_i);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & ~RSV_MASK) != '0) |=> ((status_q & $past(set_i & ~RSV_MASK)) == $past(set_i & ~RSV_MASK)));

  // R5
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_i == '0) |=> (status_q == ($past(status_q) & $past(keep_i) & ~RSV_MASK)));

  // R5
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_i == '0) |=> $stable(status_q));
endmodule

// File: rtl/usbirq_vector_unit.sv
module usbirq_vector_unit
  import usbirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              flag_o
);
  logic             any_pend;
  logic [VEC_W-1:0] vec_q;
  logic             flag_q;

  assign any_pend = |status_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (any_pend) begin
        vec_q  <= top_pending_code(status_i);
        flag_q <= 1'b0;
      end else if (flag_wr_i) begin
        flag_q <= flag_wdata_i;
      end
    end
  end

  assign irq_o  = any_pend;
  assign vec_o  = vec_q;
  assign flag_o = flag_q;

  // R8
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> (vec_q != '0));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> $stable(vec_q));

  // R9 R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> !flag_q);
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usbirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_ovr_i,
  input  logic [CAUSE_W-1:0] err_cause_i,
  input  logic [NOTE_W-1:0]  note_ev_i,
  input  logic               cpu_wr,
  input  logic               cpu_addr,
  input  logic [STAT_W-1:0]  cpu_wdata,
  output logic [STAT_W-1:0]  cpu_rdata,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               ctl_flag_o
);
  logic              err_any;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status;
  logic              stat_wr;
  logic              vec_wr;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(cpu_addr);
  assign stat_wr = cpu_wr && (sel == SEL_STATUS);
  assign vec_wr  = cpu_wr && (sel == SEL_VECTOR);

  usbirq_err_merge #(.N(CAUSE_W)) u_err (
    .cause_i (err_cause_i),
    .err_o   (err_any)
  );

  always_comb begin
    set_vec                        = '0;
    set_vec[DMA_BIT]               = dma_ovr_i;
    set_vec[ERR_BIT]               = err_any;
    set_vec[NOTE_W-1:0]            = note_ev_i;
  end

  usbirq_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .wr_i     (stat_wr),
    .keep_i   (cpu_wdata),
    .status_o (status)
  );

  usbirq_vector_unit u_vec (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_i     (status),
    .flag_wr_i    (vec_wr),
    .flag_wdata_i (cpu_wdata[0]),
    .irq_o        (irq_o),
    .vec_o        (vec_o),
    .flag_o       (ctl_flag_o)
  );

  always_comb begin
    if (sel == SEL_STATUS) cpu_rdata = status;
    else                   cpu_rdata = {3'b000, vec_o, ctl_flag_o};
  end

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |-> !cpu_rdata[RSV_BIT]);

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cause_i != '0) |=> status[ERR_BIT]);

  // R3
  dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ovr_i |=> status[DMA_BIT]);

  // R7
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status != '0));
endmodule

// File: tb/usb_irq_status_tb.sv
module usb_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dma_ovr_i;
  logic [4:0] err_cause_i;
  logic [4:0] note_ev_i;
  logic       cpu_wr;
  logic       cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       irq_o;
  logic [3:0] vec_o;
  logic       ctl_flag_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] m_stat;
  logic [3:0] m_vec;
  logic       m_flag;

  always #4 clk = ~clk;

  usb_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .dma_ovr_i(dma_ovr_i), .err_cause_i(err_cause_i),
    .note_ev_i(note_ev_i), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_o(irq_o), .vec_o(vec_o), .ctl_flag_o(ctl_flag_o)
  );

  function automatic logic [3:0] exp_code(input logic [7:0] s);
    logic [3:0] c = 4'd0;
    for (int i = 0; i < 7; i++) if (s[i]) c = 4'(i + 1);
    return c;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cpu_addr = 1'b0; #1;
    check({tag, " status"}, cpu_rdata, m_stat);
    check({"R7 irq ", tag}, {7'd0, irq_o}, {7'd0, (m_stat != 8'h00)});
    cpu_addr = 1'b1; #1;
    check({"R8/R9 vecloc ", tag}, cpu_rdata, {3'b000, m_vec, m_flag});
    check({"R8 vec_o ", tag}, {4'd0, vec_o}, {4'd0, m_vec});
    check({"R9 flag ", tag}, {7'd0, ctl_flag_o}, {7'd0, m_flag});
  endtask

  task automatic cyc(input logic d, input logic [4:0] e, input logic [4:0] n,
                     input logic w, input logic a, input logic [7:0] wd, input string tag);
    logic [7:0] set;
    logic [7:0] kept;
    dma_ovr_i = d; err_cause_i = e; note_ev_i = n;
    cpu_wr = w; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk); #1;
    set  = {1'b0, d, (e != 5'd0), n};
    kept = (w && !a) ? (m_stat & wd) : m_stat;
    if (m_stat != 8'h00) begin
      m_vec  = exp_code(m_stat);
      m_flag = 1'b0;
    end else if (w && a) begin
      m_flag = wd[0];
    end
    m_stat = (set | kept) & 8'h7F;
    @(negedge clk);
    dma_ovr_i = 0; err_cause_i = 0; note_ev_i = 0; cpu_wr = 0; cpu_wdata = 0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic clr_all(input string tag);
    cyc(0, 0, 0, 1, 0, 8'h00, tag);
    idle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; dma_ovr_i = 0; err_cause_i = 0; note_ev_i = 0;
    cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    m_stat = 0; m_vec = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;

    // R2: bit 7 cannot be written
    cyc(0, 0, 0, 1, 0, 8'h80, "R2 write80");
    cyc(1, 5'h1F, 5'h1F, 0, 0, 8'h00, "R2 fill");
    cyc(0, 0, 0, 1, 0, 8'hFF, "R2 keepall");
    idle("R2 hold");
    clr_all("R5 clearall");

    // R3: each notification bit and the DMA bit individually
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 5'(1 << k), 0, 0, 8'h00, "R3 note");
      clr_all("R3 clr");
    end
    cyc(1, 0, 0, 0, 0, 8'h00, "R3 dma");
    clr_all("R3 clr");

    // R4: every error cause alone
    for (int k = 0; k < 5; k++) begin
      cyc(0, 5'(1 << k), 0, 0, 0, 8'h00, "R4 cause");
      clr_all("R4 clr");
    end

    // R5: selective clear
    cyc(1, 5'h01, 5'h15, 0, 0, 8'h00, "R5 setup");
    cyc(0, 0, 0, 1, 0, 8'hDB, "R5 partial");
    idle("R5 after");
    clr_all("R5 clr");

    // R6: set and clear on the same bit
    cyc(0, 0, 5'h02, 0, 0, 8'h00, "R6 setup");
    cyc(0, 0, 5'h02, 1, 0, 8'h00, "R6 collide");
    clr_all("R6 clr");

    // R9 / R10: flag write, then race with hardware clear
    cyc(0, 0, 0, 1, 1, 8'h01, "R9 flagset");
    cyc(0, 0, 5'h01, 0, 0, 8'h00, "R9 event");
    cyc(0, 0, 0, 1, 1, 8'h01, "R10 race");
    clr_all("R10 clr");
    cyc(0, 0, 0, 1, 1, 8'h01, "R9 flagset2");
    cyc(0, 0, 0, 1, 1, 8'h00, "R9 flagclr");

    // R8: priority with several bits
    cyc(1, 5'h04, 5'h09, 0, 0, 8'h00, "R8 multi");
    cyc(0, 0, 0, 1, 0, 8'hBF, "R8 drop6");
    cyc(0, 0, 0, 1, 0, 8'h9F, "R8 drop5");
    idle("R8 next");
    clr_all("R8 empty");
    idle("R8 hold");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic       d;
      logic [4:0] e, n;
      logic       w, a;
      logic [7:0] wd;
      d  = ($urandom % 16) == 0;
      e  = (($urandom % 8) == 0) ? 5'($urandom) : 5'd0;
      n  = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      w  = ($urandom % 3) == 0;
      a  = ($urandom % 4) == 0;
      wd = 8'($urandom);
      cyc(d, e, n, w, a, wd, "R3/R5/R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule